// File: doc/BRIEF.md
# Segment-Based Memory Protection Unit

This block checks each memory access against a small table of foreground protection segments. Each segment is described only by its start address. It covers every address from that start up to, but not including, the start of the next segment in table order. The last segment runs to the top of the address space. A fixed background map, set by parameters, has the same shape and supplies the attributes whenever the foreground table does not give a single enabled answer.

Every segment carries an attribute word. A 4-bit rights code in that word is turned into read, write and execute permission, and the meaning of the code depends on whether the access comes from the most privileged ring (ring 0) or from any other ring. Translation is the identity, so no address is produced.

Three interfaces share the block:
- a write port that loads one foreground segment, or the whole enable mask;
- a read-back port;
- a probe port that returns a packed summary word for an address.

The lookup and probe paths are combinational from the registered table.

Top module: `mpu_segment_unit`

## Requirements
- R1: Foreground segment i contains address A when A >= start[i] and either i is NUM_FG-1 or A < start[i+1] (unsigned compares).
- R2: When two or more foreground segments contain the lookup address, chk_fault is 1, chk_granted is 0 and chk_perm is 0. When two or more contain the probe address, prb_fault is 1 and prb_result is 0.
- R3: Foreground attributes apply only when exactly one foreground segment matches and its enable bit is 1. Otherwise the background segment that contains the address supplies the attributes. The default background map has starts 0x00000000, 0x40000000, 0x80000000 and 0xC0000000, with attributes 0x00000700, 0x00012D00, 0x00000A00 and 0x00000000.
- R4: A stored attribute word keeps bits [20:8] of seg_wr_ctl; every other bit reads as 0. The rights code is attribute bits [11:8].
- R5: For ring 0, chk_perm = {R,W,X} decodes as follows: codes 4..7 give R, RX, RW, RWX; code 8 gives W; codes 9 and 10 give RW; code 11 gives RWX; codes 12..15 give R, RX, RW, RWX; codes 0..3 give nothing.
- R6: For rings 1..3, code 8 gives W, code 9 gives RWX, code 10 gives R, code 11 gives RX, and codes 12..15 give R, RX, RW, RWX. Codes 0..7 give nothing.
- R7: chk_kind selects the permission tested: 0 read, 1 write, 2 execute. Kind 3 is never granted.
- R8: A segment write (seg_wr_en) uses seg_wr_ctl[4:0] as the segment number. It stores seg_wr_addr aligned down to 2^ALIGN_LOG2 as the start and seg_wr_addr[0] as that segment's enable bit. It takes effect at the next clock edge. Numbers >= NUM_FG change nothing.
- R9: The enable mask is 0 after reset. A mask write loads mask_wr_data[NUM_FG-1:0]. When a mask write and an in-range segment write fall in the same cycle, the segment write's enable bit wins for its segment.
- R10: A probe whose address hits exactly one enabled segment returns attr | number | bit 31. A probe that hits exactly one disabled segment returns background attr | number, with bits 31 and 30 clear. A probe that hits no foreground segment returns background attr | bit 30.
- R11: Read-back gives rd_start_word = start | enable bit in bit 0, and rd_attr_word = the attribute word. Both are 0 when rd_idx >= NUM_FG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_wr_en | input | 1 | Write one foreground segment |
| seg_wr_ctl | input | 32 | Segment number [4:0] and attribute bits [20:8] |
| seg_wr_addr | input | 32 | Start address; bit 0 is the enable bit |
| mask_wr_en | input | 1 | Load the enable mask |
| mask_wr_data | input | 32 | New enable mask, low NUM_FG bits used |
| rd_idx | input | 5 | Segment number to read back |
| rd_start_word | output | 32 | Start address with enable in bit 0 |
| rd_attr_word | output | 32 | Attribute word |
| chk_addr | input | 32 | Address to check |
| chk_ring | input | 2 | Privilege ring of the access |
| chk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| chk_fault | output | 1 | Multi-hit fault |
| chk_granted | output | 1 | Access allowed |
| chk_perm | output | 3 | Decoded {R,W,X} |
| prb_addr | input | 32 | Address to probe |
| prb_result | output | 32 | Probe summary word |
| prb_fault | output | 1 | Multi-hit fault on probe |

## Verification
The bench aims at the address exactly one below a segment start and exactly at it. A containment test with an off-by-one or a signed compare would report the wrong segment number there. It loads the table out of order so that two segments overlap: a design that picked the first hit without counting would grant an access instead of faulting. It sweeps every rights code for ring 0 and for a non-zero ring, which catches a swapped or shared decode table. It also hits a segment whose enable bit is clear, hits the same-cycle collision between a mask write and a segment write, and writes a segment number past the end of the table. A design that handled these wrongly would use foreground attributes it should skip, or corrupt a real segment.

// File: rtl/mpu_seg_pkg.sv
package mpu_seg_pkg;

    localparam logic [31:0] ATTR_KEEP = 32'h001F_FF00;
    localparam int          RIGHTS_LO = 8;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    // Rights code to permission; priv selects the ring-0 table.
    function automatic perm_t decode_rights(input logic [3:0] code, input logic priv);
        perm_t p;
        p = '0;
        if (priv) begin
            unique case (code)
                4'd4, 4'd12:        p = '{r: 1'b1, w: 1'b0, x: 1'b0};
                4'd5, 4'd13:        p = '{r: 1'b1, w: 1'b0, x: 1'b1};
                4'd6, 4'd9, 4'd10,
                4'd14:              p = '{r: 1'b1, w: 1'b1, x: 1'b0};
                4'd7, 4'd11, 4'd15: p = '{r: 1'b1, w: 1'b1, x: 1'b1};
                4'd8:               p = '{r: 1'b0, w: 1'b1, x: 1'b0};
                default:            p = '0;
            endcase
        end else begin
            unique case (code)
                4'd8:         p = '{r: 1'b0, w: 1'b1, x: 1'b0};
                4'd9, 4'd15:  p = '{r: 1'b1, w: 1'b1, x: 1'b1};
                4'd10, 4'd12: p = '{r: 1'b1, w: 1'b0, x: 1'b0};
                4'd11, 4'd13: p = '{r: 1'b1, w: 1'b0, x: 1'b1};
                4'd14:        p = '{r: 1'b1, w: 1'b1, x: 1'b0};
                default:      p = '0;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/mpu_fg_match.sv
module mpu_fg_match #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0][31:0] starts,
    input  logic [31:0]        addr,
    output logic               multi,
    output logic               single,
    output logic [IW-1:0]      idx
);
    logic [N-1:0] hit;
    logic         found;

    for (genvar i = 0; i < N; i++) begin : g_seg
        if (i == N - 1) begin : g_last
            assign hit[i] = (addr >= starts[i]);
        end else begin : g_mid
            assign hit[i] = (addr >= starts[i]) && (addr < starts[i+1]);
        end
    end

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && !found) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end

    assign multi  = ($countones(hit) > 1);
    assign single = ($countones(hit) == 1);

endmodule

// File: rtl/mpu_bg_map.sv
module mpu_bg_map #(
    parameter int              N      = 4,
    parameter logic [N*32-1:0] STARTS = '0,
    parameter logic [N*32-1:0] ATTRS  = '0
) (
    input  logic [31:0] addr,
    output logic [31:0] attr
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_bg
        if (i == N - 1) begin : g_last
            assign hit[i] = (addr >= STARTS[i*32 +: 32]);
        end else begin : g_mid
            assign hit[i] = (addr >= STARTS[i*32 +: 32]) && (addr < STARTS[(i+1)*32 +: 32]);
        end
    end

    always_comb begin
        attr = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) attr = ATTRS[i*32 +: 32];
        end
    end

endmodule

// File: rtl/mpu_rights_decode.sv
module mpu_rights_decode
    import mpu_seg_pkg::*;
(
    input  logic [3:0] code,
    input  logic [1:0] ring,
    input  logic [1:0] kind,
    input  logic       block,
    output logic [2:0] perm,
    output logic       granted
);
    perm_t     p;
    acc_kind_e k;

    always_comb begin
        p = block ? perm_t'(3'b000) : decode_rights(code, ring == 2'd0);
        k = acc_kind_e'(kind);
        unique case (k)
            ACC_LOAD:  granted = p.r;
            ACC_STORE: granted = p.w;
            ACC_FETCH: granted = p.x;
            default:   granted = 1'b0;
        endcase
        perm = p;
    end

endmodule

// File: rtl/mpu_segment_unit.sv
module mpu_segment_unit
    import mpu_seg_pkg::*;
#(
    parameter int                   NUM_FG    = 8,
    parameter int                   ALIGN_LOG2 = 12,
    parameter int                   NUM_BG    = 4,
    parameter logic [NUM_BG*32-1:0] BG_START  = {32'hC000_0000, 32'h8000_0000,
                                                 32'h4000_0000, 32'h0000_0000},
    parameter logic [NUM_BG*32-1:0] BG_ATTR   = {32'h0000_0000, 32'h0000_0A00,
                                                 32'h0001_2D00, 32'h0000_0700}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seg_wr_en,
    input  logic [31:0] seg_wr_ctl,
    input  logic [31:0] seg_wr_addr,
    input  logic        mask_wr_en,
    input  logic [31:0] mask_wr_data,
    input  logic [4:0]  rd_idx,
    output logic [31:0] rd_start_word,
    output logic [31:0] rd_attr_word,
    input  logic [31:0] chk_addr,
    input  logic [1:0]  chk_ring,
    input  logic [1:0]  chk_kind,
    output logic        chk_fault,
    output logic        chk_granted,
    output logic [2:0]  chk_perm,
    input  logic [31:0] prb_addr,
    output logic [31:0] prb_result,
    output logic        prb_fault
);
    localparam int          IW         = (NUM_FG > 1) ? $clog2(NUM_FG) : 1;
    localparam logic [31:0] ALIGN_MASK = ~((32'd1 << ALIGN_LOG2) - 32'd1);
    localparam logic [31:0] PRB_VALID  = 32'h8000_0000;
    localparam logic [31:0] PRB_BG     = 32'h4000_0000;

    typedef struct packed {
        logic [NUM_FG-1:0][31:0] start;
        logic [NUM_FG-1:0][31:0] attr;
        logic [NUM_FG-1:0]       en;
    } seg_state_t;

    seg_state_t state_d, state_q;

    logic          wr_in_range;
    logic [IW-1:0] wr_sel;
    logic          rd_in_range;
    logic [IW-1:0] rd_sel;

    assign wr_in_range = (int'(seg_wr_ctl[4:0]) < NUM_FG);
    assign wr_sel      = seg_wr_ctl[IW-1:0];
    assign rd_in_range = (int'(rd_idx) < NUM_FG);
    assign rd_sel      = rd_idx[IW-1:0];

    always_comb begin
        state_d = state_q;
        if (mask_wr_en) begin
            state_d.en = mask_wr_data[NUM_FG-1:0];
        end
        if (seg_wr_en && wr_in_range) begin
            state_d.start[wr_sel] = seg_wr_addr & ALIGN_MASK;
            state_d.attr[wr_sel]  = seg_wr_ctl & ATTR_KEEP;
            state_d.en[wr_sel]    = seg_wr_addr[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Read-back path
    always_comb begin
        rd_start_word = '0;
        rd_attr_word  = '0;
        if (rd_in_range) begin
            rd_start_word = state_q.start[rd_sel] | {31'd0, state_q.en[rd_sel]};
            rd_attr_word  = state_q.attr[rd_sel];
        end
    end

    // Access check path
    logic          c_multi, c_single;
    logic [IW-1:0] c_idx;
    logic [31:0]   c_bg_attr, c_attr;
    logic          c_use_fg;

    mpu_fg_match #(.N(NUM_FG), .IW(IW)) u_chk_match (
        .starts (state_q.start),
        .addr   (chk_addr),
        .multi  (c_multi),
        .single (c_single),
        .idx    (c_idx)
    );

    mpu_bg_map #(.N(NUM_BG), .STARTS(BG_START), .ATTRS(BG_ATTR)) u_chk_bg (
        .addr (chk_addr),
        .attr (c_bg_attr)
    );

    assign c_use_fg = c_single && state_q.en[c_idx];
    assign c_attr   = c_use_fg ? state_q.attr[c_idx] : c_bg_attr;

    mpu_rights_decode u_rights (
        .code    (c_attr[RIGHTS_LO +: 4]),
        .ring    (chk_ring),
        .kind    (chk_kind),
        .block   (c_multi),
        .perm    (chk_perm),
        .granted (chk_granted)
    );

    assign chk_fault = c_multi;

    // Probe path
    logic          p_multi, p_single;
    logic [IW-1:0] p_idx;
    logic [31:0]   p_bg_attr;
    logic [31:0]   p_idx_word;

    mpu_fg_match #(.N(NUM_FG), .IW(IW)) u_prb_match (
        .starts (state_q.start),
        .addr   (prb_addr),
        .multi  (p_multi),
        .single (p_single),
        .idx    (p_idx)
    );

    mpu_bg_map #(.N(NUM_BG), .STARTS(BG_START), .ATTRS(BG_ATTR)) u_prb_bg (
        .addr (prb_addr),
        .attr (p_bg_attr)
    );

    assign p_idx_word = {{(32-IW){1'b0}}, p_idx};

    always_comb begin
        if (p_multi) begin
            prb_result = '0;
        end else if (p_single && state_q.en[p_idx]) begin
            prb_result = state_q.attr[p_idx] | p_idx_word | PRB_VALID;
        end else if (p_single) begin
            prb_result = p_bg_attr | p_idx_word;
        end else begin
            prb_result = p_bg_attr | PRB_BG;
        end
    end

    assign prb_fault = p_multi;

endmodule

// File: rtl/mpu_segment_unit_chk.sv
module mpu_segment_unit_chk #(
    parameter int NUM_FG = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seg_wr_en,
    input logic [31:0]       seg_wr_ctl,
    input logic              mask_wr_en,
    input logic [31:0]       mask_wr_data,
    input logic [NUM_FG-1:0] en_mask,
    input logic              chk_fault,
    input logic              chk_granted,
    input logic [1:0]        chk_kind,
    input logic              prb_fault,
    input logic [31:0]       prb_result
);
    // R2
    multi_hit_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fault |-> !chk_granted);

    // R2
    probe_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prb_fault |-> (prb_result == 32'd0));

    // R7
    no_kind_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_kind == 2'd3) |-> !chk_granted);

    // R10
    probe_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prb_result[31] && prb_result[30]));

    // R9
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_en && !seg_wr_en) |=> (en_mask == $past(mask_wr_data[NUM_FG-1:0])));

    // R8
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_wr_en && !mask_wr_en && (int'(seg_wr_ctl[4:0]) >= NUM_FG)) |=> $stable(en_mask));

endmodule

bind mpu_segment_unit mpu_segment_unit_chk #(.NUM_FG(NUM_FG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .seg_wr_en    (seg_wr_en),
    .seg_wr_ctl   (seg_wr_ctl),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .en_mask      (state_q.en),
    .chk_fault    (chk_fault),
    .chk_granted  (chk_granted),
    .chk_kind     (chk_kind),
    .prb_fault    (prb_fault),
    .prb_result   (prb_result)
);

// File: tb/mpu_segment_unit_tb_top.sv
`timescale 1ns/1ps
module mpu_segment_unit_tb_top;

    localparam int NFG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [31:0] seg_wr_ctl = '0;
    logic [31:0] seg_wr_addr = '0;
    logic        mask_wr_en = 1'b0;
    logic [31:0] mask_wr_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_start_word, rd_attr_word;
    logic [31:0] chk_addr = '0;
    logic [1:0]  chk_ring = '0;
    logic [1:0]  chk_kind = '0;
    logic        chk_fault, chk_granted;
    logic [2:0]  chk_perm;
    logic [31:0] prb_addr = '0;
    logic [31:0] prb_result;
    logic        prb_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] m_start [NFG];
    logic [31:0] m_attr  [NFG];
    logic [NFG-1:0] m_en;

    always #2.5 clk = ~clk;

    mpu_segment_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_ctl(seg_wr_ctl), .seg_wr_addr(seg_wr_addr),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .rd_idx(rd_idx), .rd_start_word(rd_start_word), .rd_attr_word(rd_attr_word),
        .chk_addr(chk_addr), .chk_ring(chk_ring), .chk_kind(chk_kind),
        .chk_fault(chk_fault), .chk_granted(chk_granted), .chk_perm(chk_perm),
        .prb_addr(prb_addr), .prb_result(prb_result), .prb_fault(prb_fault)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Background map, as listed in R3
    function automatic logic [31:0] bg_attr(input logic [31:0] a);
        if (a >= 32'hC000_0000) return 32'h0;
        if (a >= 32'h8000_0000) return 32'h0000_0A00;
        if (a >= 32'h4000_0000) return 32'h0001_2D00;
        return 32'h0000_0700;
    endfunction

    // Foreground hits per R1
    function automatic void fg_hits(input logic [31:0] a, output int cnt, output int first);
        cnt = 0; first = 0;
        for (int i = 0; i < NFG; i++) begin
            if (a >= m_start[i] && (i == NFG-1 || a < m_start[i+1])) begin
                if (cnt == 0) first = i;
                cnt++;
            end
        end
    endfunction

    // R5 / R6 tables, {R,W,X}
    function automatic logic [2:0] exp_perm(input logic [3:0] c, input logic [1:0] ring);
        if (ring == 2'd0) begin
            case (c)
                4,12: return 3'b100;  5,13: return 3'b101;
                6,9,10,14: return 3'b110; 7,11,15: return 3'b111;
                8: return 3'b010; default: return 3'b000;
            endcase
        end
        case (c)
            8: return 3'b010; 9,15: return 3'b111; 10,12: return 3'b100;
            11,13: return 3'b101; 14: return 3'b110; default: return 3'b000;
        endcase
    endfunction

    task automatic write_cycle(input bit sw, input logic [31:0] p, input logic [31:0] v,
                               input bit mw, input logic [31:0] m);
        int idx;
        @(negedge clk);
        seg_wr_en = sw; seg_wr_ctl = p; seg_wr_addr = v;
        mask_wr_en = mw; mask_wr_data = m;
        @(negedge clk);
        seg_wr_en = 1'b0; mask_wr_en = 1'b0;
        if (mw) m_en = m[NFG-1:0];
        idx = int'(p[4:0]);
        if (sw && idx < NFG) begin
            m_start[idx] = v & 32'hFFFF_F000;
            m_attr[idx]  = p & 32'h001F_FF00;
            m_en[idx]    = v[0];
        end
    endtask

    task automatic check_read(input string tag, input logic [4:0] idx);
        logic [31:0] es, ea;
        @(negedge clk); rd_idx = idx; #1;
        es = 0; ea = 0;
        if (int'(idx) < NFG) begin
            es = m_start[idx] | {31'd0, m_en[idx]};
            ea = m_attr[idx];
        end
        check32({tag, " start"}, rd_start_word, es);
        check32({tag, " attr"}, rd_attr_word, ea);
    endtask

    task automatic check_access(input string tag, input logic [31:0] a,
                                input logic [1:0] ring, input logic [1:0] kind);
        int cnt, first;
        logic [31:0] at;
        logic [2:0]  ep;
        logic        eg;
        @(negedge clk); chk_addr = a; chk_ring = ring; chk_kind = kind; #1;
        fg_hits(a, cnt, first);
        at = (cnt == 1 && m_en[first]) ? m_attr[first] : bg_attr(a);
        ep = (cnt > 1) ? 3'b000 : exp_perm(at[11:8], ring);
        eg = (kind == 2'd0) ? ep[2] : (kind == 2'd1) ? ep[1] : (kind == 2'd2) ? ep[0] : 1'b0;
        check32({tag, " fault"}, {31'd0, chk_fault}, {31'd0, cnt > 1});
        check32({tag, " perm"}, {29'd0, chk_perm}, {29'd0, ep});
        check32({tag, " grant"}, {31'd0, chk_granted}, {31'd0, eg});
    endtask

    task automatic check_probe(input string tag, input logic [31:0] a);
        int cnt, first;
        logic [31:0] er;
        @(negedge clk); prb_addr = a; #1;
        fg_hits(a, cnt, first);
        if (cnt > 1) er = 0;
        else if (cnt == 1 && m_en[first]) er = m_attr[first] | first | 32'h8000_0000;
        else if (cnt == 1) er = bg_attr(a) | first;
        else er = bg_attr(a) | 32'h4000_0000;
        check32({tag, " result"}, prb_result, er);
        check32({tag, " fault"}, {31'd0, prb_fault}, {31'd0, cnt > 1});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [31:0] r;
        seed = 32'h5EED;
        r = $urandom(seed);
        for (int i = 0; i < NFG; i++) begin m_start[i] = 0; m_attr[i] = 0; end
        m_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R9, R11)
        check_read("R9 reset seg3", 5'd3);
        check_read("R11 reset seg0", 5'd0);
        check_probe("R10 reset probe", 32'h5000_0000);

        // Ordered table, all enabled, varied rights
        for (int i = 0; i < NFG; i++)
            write_cycle(1, 32'h0000_0000 | ((i + 4) << 8) | i, (i + 1) * 32'h1000_0000 + 1, 0, 0);
        check_read("R8 seg2", 5'd2);
        check_probe("R10 no fg hit", 32'h0800_0000);
        check_probe("R10 enabled hit", 32'h3000_0010);
        // R1 boundaries
        check_probe("R1 below start", 32'h2FFF_FFFF);
        check_probe("R1 at start", 32'h3000_0000);
        check_probe("R1 last seg top", 32'hFFFF_FFFF);

        // R8 alignment and enable bit, R4 attribute masking
        write_cycle(1, 32'hFFFF_FF03, 32'h4234_5679, 0, 0);
        check_read("R8 align", 5'd3);
        check_read("R4 attr mask", 5'd3);
        write_cycle(1, 32'h0000_0503, 32'h4000_0000, 0, 0);
        check_read("R8 enable clear", 5'd3);
        // R8 out-of-range write ignored, R11 out-of-range read
        write_cycle(1, 32'h0000_0F09, 32'h0000_0001, 0, 0);
        for (int i = 0; i < NFG; i++) check_read("R8 oob untouched", 5'(i));
        check_read("R11 oob read", 5'd9);

        // R9 mask masking and same-cycle priority
        write_cycle(0, 0, 0, 1, 32'hFFFF_FFFF);
        check_read("R9 mask all seg3", 5'd3);
        write_cycle(1, 32'h0000_0702, 32'h3000_0001, 1, 32'h0);
        check_read("R9 priority seg2", 5'd2);
        check_read("R9 priority seg4", 5'd4);

        // R3 disabled single hit falls back; enabled uses foreground
        check_access("R3 disabled", 32'h5000_0000, 2'd0, 2'd0);
        check_probe("R10 disabled hit", 32'h5000_0000);
        check_access("R3 enabled", 32'h3100_0000, 2'd1, 2'd1);

        // R5 / R6 full rights sweep on segment 1
        for (int c = 0; c < 16; c++) begin
            write_cycle(1, 32'h0000_0001 | (c << 8), 32'h2000_0001, 0, 0);
            check_access("R5 ring0", 32'h2000_0100, 2'd0, 2'd0);
            check_access("R6 ring2", 32'h2000_0100, 2'd2, 2'd0);
            check_access("R7 write", 32'h2000_0100, 2'd0, 2'd1);
            check_access("R7 fetch", 32'h2000_0100, 2'd3, 2'd2);
            check_access("R7 kind3", 32'h2000_0100, 2'd0, 2'd3);
        end

        // R2 overlapping segments
        write_cycle(1, 32'h0000_0F06, 32'h2000_0001, 0, 0);
        check_access("R2 multi", 32'h2100_0000, 2'd0, 2'd0);
        check_probe("R2 multi probe", 32'h2100_0000);

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            int sidx;
            logic [31:0] a;
            op = int'($urandom % 6);
            sidx = int'($urandom % 10);
            a = ($urandom % 2) ? $urandom :
                (32'(sidx % NFG) + 1) * 32'h1000_0000 + ($urandom % 3) - 1;
            case (op)
                0: write_cycle(1, ($urandom & 32'h001F_FF00) | sidx,
                               ($urandom % 4 == 0) ? $urandom
                               : (32'(sidx) + 1) * 32'h1000_0000 + ($urandom & 32'hFFFF), 0, 0);
                1: write_cycle(0, 0, 0, 1, $urandom);
                2: check_read("R11 random", 5'($urandom));
                3: check_probe("R10 random", a);
                default: check_access("R3 random", a, 2'($urandom), 2'($urandom));
            endcase
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule